// File: doc/BRIEF.md
# Dual-Source Bus Ready Combiner

This block produces the single active-low ready that ends a processor bus cycle. It follows each cycle from a start strobe. The cycle passes through a one-clock status phase and then a command phase that repeats as wait states. The cycle ends when an enabled completion source is seen.

There are two completion sources. The synchronous ready is used on the clock edge where it is sampled. The asynchronous ready first passes, together with its enable, through a chain of synchronizer flops. Address decode logic drives a separate active-low enable for each source on every cycle. A source whose enable is high has no effect. Since the asynchronous path acts only in the command phase and carries the synchronizer delay, only the synchronous source can give a zero-wait cycle.

While no cycle is in progress the ready output is held low. It goes high for the whole span of a cycle and falls again at the clock edge that completes it.

Top module: `rdy_combiner`

## Requirements
- R1: After reset, and whenever no bus cycle is in progress, `ready_no` is 0.
- R2: A `cyc_start_i` high sampled at edge k while idle makes `ready_no` 1 after edge k. The cycle is then in its status phase for one clock.
- R3: When `srdy_ni`=0 and `srdy_en_ni`=0 are sampled at the edge that closes the status phase, `ready_no` is 0 after that edge (zero wait states). The same holds at any edge that closes a command phase.
- R4: While `srdy_en_ni` is 1, the value of `srdy_ni` has no effect on `ready_no`.
- R5: If `ardy_ni`=0 and `ardy_en_ni`=0 are both present from edge e during the command phase, `ready_no` is 0 after edge e+SYNC_STAGES (default 2).
- R6: The asynchronous source never ends a cycle at the edge that closes the status phase. Without a synchronous completion there, `ready_no` stays 1 after that edge.
- R7: While `ardy_en_ni` is 1, the value of `ardy_ni` has no effect on `ready_no`.
- R8: Either source can end a cycle, and the first enabled completion to reach the combiner ends it.
- R9: `cyc_start_i` is ignored while a cycle is in progress. `ready_no` stays 1 until a completion occurs.
- R10: While no enabled source signals completion, the command phase repeats and `ready_no` stays 1.
- R11: `ardy_en_ni` passes through the same synchronizer delay as `ardy_ni`. The asynchronous completion is timed from the later of the two going low.
- R12: The environment keeps `ardy_ni` or `ardy_en_ni` high at the edge that closes the status phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_start_i | input | 1 | Bus cycle start strobe, active high |
| srdy_ni | input | 1 | Synchronous ready, active low |
| srdy_en_ni | input | 1 | Enable for synchronous ready, active low |
| ardy_ni | input | 1 | Asynchronous ready, active low |
| ardy_en_ni | input | 1 | Enable for asynchronous ready, active low |
| ready_no | output | 1 | Combined cycle ready, active low |

## Verification
The assertions check on every cycle the phase-level rules. A start taken while idle raises ready and enters the status phase. An idle state always shows ready low. A status phase with no synchronous hit never completes. A wait state with no hit stays in the command phase. Every fall of ready is traced to a qualified hit, and the environment rule on the asynchronous inputs at the end of the status phase is checked as well. The end-to-end latency through the synchronizer, the masking effect of each enable, the race between the two sources and the effect of an enable that arrives late can only be shown by the bench's scenarios. There, a behavioural model is compared with the output on every clock.

// File: rtl/rdy_pkg.sv
package rdy_pkg;
  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_SEND = 2'd1,
    BUS_CMD  = 2'd2
  } bus_state_e;
endpackage

// File: rtl/rdy_sync.sv
module rdy_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int Depth = (STAGES < 2) ? 2 : STAGES;

  logic [Depth-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {Depth{RST_VAL}};
    else         stg_q <= {stg_q[Depth-2:0], d_i};
  end

  assign q_o = stg_q[Depth-1];
endmodule

// File: rtl/rdy_qualify.sv
module rdy_qualify #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srdy_ni,
  input  logic srdy_en_ni,
  input  logic ardy_ni,
  input  logic ardy_en_ni,
  output logic s_hit_o,
  output logic a_hit_o
);
  localparam int NumAsync = 2;

  logic [NumAsync-1:0] araw;
  logic [NumAsync-1:0] asyn;

  assign araw = {ardy_en_ni, ardy_ni};

  // ready and its enable share one synchronizer delay
  for (genvar i = 0; i < NumAsync; i++) begin : g_async
    rdy_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(1'b1)
    ) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (araw[i]),
      .q_o   (asyn[i])
    );
  end

  assign s_hit_o = ~srdy_ni & ~srdy_en_ni;
  assign a_hit_o = ~|asyn;
endmodule

// File: rtl/rdy_cycle_fsm.sv
module rdy_cycle_fsm
  import rdy_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_start_i,
  input  logic s_hit_i,
  input  logic a_hit_i,
  output logic in_send_o,
  output logic ready_no
);
  bus_state_e state_q, state_d;
  logic       rdy_q, rdy_d;

  always_comb begin
    state_d = state_q;
    rdy_d   = rdy_q;
    unique case (state_q)
      BUS_IDLE: begin
        rdy_d = 1'b0;
        if (cyc_start_i) begin
          state_d = BUS_SEND;
          rdy_d   = 1'b1;
        end
      end
      BUS_SEND: begin
        // async source not honoured here: no zero-wait via synchronizer
        if (s_hit_i) begin
          state_d = BUS_IDLE;
          rdy_d   = 1'b0;
        end else begin
          state_d = BUS_CMD;
        end
      end
      BUS_CMD: begin
        if (s_hit_i || a_hit_i) begin
          state_d = BUS_IDLE;
          rdy_d   = 1'b0;
        end
      end
      default: begin
        state_d = BUS_IDLE;
        rdy_d   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BUS_IDLE;
      rdy_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rdy_q   <= rdy_d;
    end
  end

  assign ready_no  = rdy_q;
  assign in_send_o = (state_q == BUS_SEND);

  p_idle_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BUS_IDLE) |-> !rdy_q);

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BUS_IDLE && cyc_start_i) |=> (rdy_q && state_q == BUS_SEND));

  p_fall_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_q) |-> ($past(s_hit_i) || $past(a_hit_i)));

  p_no_async_zero_wait_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BUS_SEND && !s_hit_i) |=> (rdy_q && state_q == BUS_CMD));

  p_wait_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BUS_CMD && !s_hit_i && !a_hit_i) |=> (rdy_q && state_q == BUS_CMD));
endmodule

// File: rtl/rdy_combiner.sv
module rdy_combiner #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_start_i,
  input  logic srdy_ni,
  input  logic srdy_en_ni,
  input  logic ardy_ni,
  input  logic ardy_en_ni,
  output logic ready_no
);
  logic s_hit;
  logic a_hit;
  logic in_send;

  rdy_qualify #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_qualify (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .srdy_ni   (srdy_ni),
    .srdy_en_ni(srdy_en_ni),
    .ardy_ni   (ardy_ni),
    .ardy_en_ni(ardy_en_ni),
    .s_hit_o   (s_hit),
    .a_hit_o   (a_hit)
  );

  rdy_cycle_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cyc_start_i(cyc_start_i),
    .s_hit_i    (s_hit),
    .a_hit_i    (a_hit),
    .in_send_o  (in_send),
    .ready_no   (ready_no)
  );

  // environment rule on the async inputs at the end of the status phase
  p_async_quiet_send_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_send |-> (ardy_ni || ardy_en_ni));
endmodule

// File: tb/rdy_combiner_tb.sv
module rdy_combiner_tb;
  localparam int SyncStages = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic cyc = 1'b0;
  logic srdy = 1'b1, sen = 1'b1, ardy = 1'b1, aen = 1'b1;
  logic ready;

  int    checks = 0;
  int    fails = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #4 clk = ~clk;

  rdy_combiner #(.SYNC_STAGES(SyncStages)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cyc_start_i(cyc),
    .srdy_ni    (srdy),
    .srdy_en_ni (sen),
    .ardy_ni    (ardy),
    .ardy_en_ni (aen),
    .ready_no   (ready)
  );

  // behavioural reference: 0 idle, 1 status, 2 command
  int ms = 0;
  bit mr = 1'b0;
  bit qa[$] = '{1'b1, 1'b1};
  bit qe[$] = '{1'b1, 1'b1};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; mr = 1'b0;
      qa = {}; qe = {};
      for (int i = 0; i < SyncStages; i++) begin
        qa.push_back(1'b1); qe.push_back(1'b1);
      end
    end else begin
      bit sh, ah;
      sh = !srdy && !sen;
      ah = !qa[0] && !qe[0];
      if (ms == 0) begin
        if (cyc) begin ms = 1; mr = 1'b1; end
      end else if (ms == 1) begin
        if (sh) begin ms = 0; mr = 1'b0; end else ms = 2;
      end else begin
        if (sh || ah) begin ms = 0; mr = 1'b0; end
      end
      void'(qa.pop_front()); qa.push_back(ardy);
      void'(qe.pop_front()); qe.push_back(aen);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (ready !== mr) begin
        fails++;
        $display("FAIL %s model compare: ready_no=%b expected=%b", cur_req, ready, mr);
      end
    end
  end

  task automatic chk(input bit exp, input string req);
    checks++;
    if (ready !== exp) begin
      fails++;
      $display("FAIL %s directed: ready_no=%b expected=%b", req, ready, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic report();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: ready_no=%b expected=completion", ready);
    report();
  end

  initial begin
    #2 rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step(); step();
    cur_req = "R1"; chk(1'b0, "R1");

    // R2 / R3 zero wait
    cur_req = "R3";
    cyc = 1'b1; srdy = 1'b0; sen = 1'b0;
    step(); chk(1'b1, "R2"); cyc = 1'b0;
    step(); chk(1'b0, "R3");
    srdy = 1'b1; sen = 1'b1;
    step(); chk(1'b0, "R1");

    // R10 wait states then sync completion
    cur_req = "R10";
    cyc = 1'b1; step(); cyc = 1'b0; chk(1'b1, "R2");
    for (int i = 0; i < 3; i++) begin step(); chk(1'b1, "R10"); end
    srdy = 1'b0; sen = 1'b0;
    step(); chk(1'b0, "R3");
    srdy = 1'b1; sen = 1'b1;

    // R4 sync masked
    cur_req = "R4";
    cyc = 1'b1; step(); cyc = 1'b0; srdy = 1'b0;
    for (int i = 0; i < 4; i++) begin step(); chk(1'b1, "R4"); end
    sen = 1'b0; step(); chk(1'b0, "R4");
    srdy = 1'b1; sen = 1'b1;

    // R7 async masked
    cur_req = "R7";
    cyc = 1'b1; step(); cyc = 1'b0; step();
    ardy = 1'b0;
    for (int i = 0; i < 5; i++) begin step(); chk(1'b1, "R7"); end
    ardy = 1'b1; srdy = 1'b0; sen = 1'b0;
    step(); chk(1'b0, "R7");
    srdy = 1'b1; sen = 1'b1;
    step(); step();

    // R5 / R6 async latency, no zero wait
    cur_req = "R5";
    cyc = 1'b1; step(); cyc = 1'b0; chk(1'b1, "R6");
    step(); ardy = 1'b0; aen = 1'b0;
    step(); chk(1'b1, "R6");
    step(); chk(1'b1, "R5");
    step(); chk(1'b0, "R5");
    ardy = 1'b1; aen = 1'b1;
    step(); step();

    // R11 late enable governs timing
    cur_req = "R11";
    cyc = 1'b1; step(); cyc = 1'b0; step();
    ardy = 1'b0; step(); step();
    aen = 1'b0;
    step(); chk(1'b1, "R11");
    step(); chk(1'b1, "R11");
    step(); chk(1'b0, "R11");
    ardy = 1'b1; aen = 1'b1;
    step(); step();

    // R8 sync overtakes a pending async
    cur_req = "R8";
    cyc = 1'b1; step(); cyc = 1'b0; step();
    ardy = 1'b0; aen = 1'b0; step();
    srdy = 1'b0; sen = 1'b0;
    step(); chk(1'b0, "R8");
    ardy = 1'b1; aen = 1'b1; srdy = 1'b1; sen = 1'b1;
    step(); step();

    // R9 start ignored while busy, then back-to-back cycle
    cur_req = "R9";
    cyc = 1'b1; step(); chk(1'b1, "R2");
    step(); step(); chk(1'b1, "R9");
    cyc = 1'b0; srdy = 1'b0; sen = 1'b0;
    step(); chk(1'b0, "R9");
    srdy = 1'b1; sen = 1'b1; cyc = 1'b1;
    step(); chk(1'b1, "R2");
    cyc = 1'b0; srdy = 1'b0; sen = 1'b0;
    step(); chk(1'b0, "R3");
    srdy = 1'b1; sen = 1'b1;
    step(); step();

    // mixed traffic, R12 respected by keeping async quiet in status phase
    cur_req = "R8";
    for (int n = 0; n < 1500; n++) begin
      cyc  = ($urandom % 3) == 0;
      srdy = ($urandom % 4) != 0;
      sen  = ($urandom % 2) != 0;
      aen  = ($urandom % 3) == 0;
      ardy = (ms == 1) ? 1'b1 : (($urandom % 2) != 0);
      step();
    end
    cyc = 1'b0; srdy = 1'b1; sen = 1'b1; ardy = 1'b1; aen = 1'b1;
    step();
    report();
  end
endmodule